// File: doc/BRIEF.md
# Function-Unit Register Dependency Matrix

This block is the register-dependency half of an out-of-order issue scoreboard. It holds one row per function unit and one column per architectural register. When a function unit is issued, its row records which register it will write and which two registers it will read; the registers arrive as one-hot vectors. Each recorded bit stays set until the row's go-write strobe clears the destination or its go-read strobe clears both sources.

From the recorded bits the matrix builds two per-register summaries. Read-pending is set when any row still has that register as a source. Write-pending is set when any row still has it as a destination. These summaries go back to every row as hazard inputs. A destination bit that meets read-pending raises a forward-progress (hazard) flag, which marks write-after-read. A source bit that meets write-pending raises the flag for read-after-write. The same bits drive register-file select lines while the matching go strobe is high.

A recorded bit counts as active in the cycle it is issued. It also stays active through the cycle in which its go strobe clears it, so the select line is valid for exactly one cycle of go. Everything is synchronous to one rising-edge clock.

Top module: `fu_reg_depmatrix`

## Requirements
- R1: After synchronous reset, with no issue strobe, every stored bit is clear: `rd_pend`, `wr_pend`, all forward-progress outputs and all select outputs read zero.
- R2: When `issue[f]` is high, bit r of `dst_oh[f]`, `s1_oh[f]` or `s2_oh[f]` records that role for register r in row f. The bit counts as active in that same cycle and in every later cycle until it is cleared.
- R3: `go_wr[f]` clears row f's destination bits and `go_rd[f]` clears both of its source bits. A cleared bit is still active in the cycle the strobe is high and inactive from the next cycle on, even if the strobe stays high.
- R4: If issue and the clearing go strobe of a row are high in the same cycle, clearing wins. The affected bit is not active in that cycle or afterwards.
- R5: A forward-progress bit (`dst_fwd`, `s1_fwd`, `s2_fwd` at [f][r]) is high only when its cell is active, its hazard input is high and `issue[f]` is low. It is always zero while `issue[f]` is high.
- R6: A select bit (`dst_sel[f][r]`, `s1_sel`, `s2_sel`) equals the cell being active AND its go strobe: `go_wr[f]` for the destination, `go_rd[f]` for the sources.
- R7: The hazard input of a destination cell is `rd_pend[r]`, which gives write-after-read protection. The hazard input of both source cells is `wr_pend[r]`, which gives read-after-write protection.
- R8: `rd_pend[r]` is the OR over all rows of (source-1 active OR source-2 active) in column r. `wr_pend[r]` is the OR over all rows of destination active.
- R9: Strobes of one row never set, clear or select the bits of any other row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | NFU | Per-row issue strobe |
| go_rd | input | NFU | Per-row go-read strobe, clears sources |
| go_wr | input | NFU | Per-row go-write strobe, clears destination |
| dst_oh | input | NFU x NREG | One-hot destination register per row |
| s1_oh | input | NFU x NREG | One-hot first source register per row |
| s2_oh | input | NFU x NREG | One-hot second source register per row |
| dst_fwd | output | NFU x NREG | Destination forward-progress (write-after-read hazard) |
| s1_fwd | output | NFU x NREG | Source-1 forward-progress (read-after-write hazard) |
| s2_fwd | output | NFU x NREG | Source-2 forward-progress (read-after-write hazard) |
| dst_sel | output | NFU x NREG | Destination register-file select |
| s1_sel | output | NFU x NREG | Source-1 register-file select |
| s2_sel | output | NFU x NREG | Source-2 register-file select |
| rd_pend | output | NREG | Global per-register read-pending |
| wr_pend | output | NREG | Global per-register write-pending |

## Verification
Two pairs of events can fall into the same cycle. In the first, a row's issue and its own go strobe coincide, so setting and clearing act on one cell at once. In the second, a go strobe clears a cell while other rows still depend on the pending summaries that cell feeds. The bench provokes the first pair directly by issuing and clearing one row together, and then with a long stretch of random per-row strobes. A behavioural model of every cell judges the select, forward-progress and pending outputs on every clock. Directed checks confirm that a select pulse lasts one cycle under a held go strobe, and that a simultaneous set and clear leaves nothing pending.

// File: rtl/dm_pkg.sv
package dm_pkg;
    // Cell roles inside one matrix row
    typedef enum logic [1:0] {
        ROLE_DST = 2'd0,
        ROLE_S1  = 2'd1,
        ROLE_S2  = 2'd2
    } dm_role_e;

    localparam int unsigned NROLE = 3;
endpackage

// File: rtl/dm_cell_vec.sv
// One role (destination or a source) of one row across all register columns.
module dm_cell_vec #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         issue,
    input  logic         go,
    input  logic [W-1:0] reg_oh,
    input  logic [W-1:0] hazard,
    output logic [W-1:0] active,
    output logic [W-1:0] fwd,
    output logic [W-1:0] sel
);
    typedef struct packed {
        logic [W-1:0] held;
    } cell_st_t;

    cell_st_t st_d, st_q;
    logic [W-1:0] set_v;
    logic [W-1:0] live;

    always_comb begin
        set_v     = issue ? reg_oh : '0;
        // clear has priority over set
        live      = go ? '0 : (st_q.held | set_v);
        st_d.held = live;
        active    = st_q.held | live;
        fwd       = issue ? '0 : (active & hazard);
        sel       = go ? active : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/dm_row.sv
// One function-unit row: three role cells sharing the row's strobes.
module dm_row
    import dm_pkg::*;
#(
    parameter int unsigned NREG = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            issue,
    input  logic            go_rd,
    input  logic            go_wr,
    input  logic [NREG-1:0] dst_oh,
    input  logic [NREG-1:0] s1_oh,
    input  logic [NREG-1:0] s2_oh,
    input  logic [NREG-1:0] rd_pend,
    input  logic [NREG-1:0] wr_pend,
    output logic [NROLE-1:0][NREG-1:0] fwd,
    output logic [NROLE-1:0][NREG-1:0] sel,
    output logic [NREG-1:0] rd_part,
    output logic [NREG-1:0] wr_part
);
    logic [NROLE-1:0][NREG-1:0] reg_in;
    logic [NROLE-1:0][NREG-1:0] haz_in;
    logic [NROLE-1:0][NREG-1:0] act;
    logic [NROLE-1:0]           go_in;

    always_comb begin
        reg_in[ROLE_DST] = dst_oh;
        reg_in[ROLE_S1]  = s1_oh;
        reg_in[ROLE_S2]  = s2_oh;
        // write-after-read guard on the destination, read-after-write on sources
        haz_in[ROLE_DST] = rd_pend;
        haz_in[ROLE_S1]  = wr_pend;
        haz_in[ROLE_S2]  = wr_pend;
        go_in[ROLE_DST]  = go_wr;
        go_in[ROLE_S1]   = go_rd;
        go_in[ROLE_S2]   = go_rd;
    end

    for (genvar k = 0; k < NROLE; k++) begin : g_role
        dm_cell_vec #(.W(NREG)) u_cell (
            .clk    (clk),
            .rst    (rst),
            .issue  (issue),
            .go     (go_in[k]),
            .reg_oh (reg_in[k]),
            .hazard (haz_in[k]),
            .active (act[k]),
            .fwd    (fwd[k]),
            .sel    (sel[k])
        );
    end

    assign rd_part = act[ROLE_S1] | act[ROLE_S2];
    assign wr_part = act[ROLE_DST];
endmodule

// File: rtl/dm_pend_or.sv
// Column-wise OR of per-row contributions.
module dm_pend_or #(
    parameter int unsigned NFU  = 4,
    parameter int unsigned NREG = 8
) (
    input  logic [NFU-1:0][NREG-1:0] part,
    output logic [NREG-1:0]          any
);
    always_comb begin
        any = '0;
        for (int f = 0; f < NFU; f++) any = any | part[f];
    end
endmodule

// File: rtl/fu_reg_depmatrix.sv
module fu_reg_depmatrix
    import dm_pkg::*;
#(
    parameter int unsigned NFU  = 4,
    parameter int unsigned NREG = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NFU-1:0]           issue,
    input  logic [NFU-1:0]           go_rd,
    input  logic [NFU-1:0]           go_wr,
    input  logic [NFU-1:0][NREG-1:0] dst_oh,
    input  logic [NFU-1:0][NREG-1:0] s1_oh,
    input  logic [NFU-1:0][NREG-1:0] s2_oh,
    output logic [NFU-1:0][NREG-1:0] dst_fwd,
    output logic [NFU-1:0][NREG-1:0] s1_fwd,
    output logic [NFU-1:0][NREG-1:0] s2_fwd,
    output logic [NFU-1:0][NREG-1:0] dst_sel,
    output logic [NFU-1:0][NREG-1:0] s1_sel,
    output logic [NFU-1:0][NREG-1:0] s2_sel,
    output logic [NREG-1:0]          rd_pend,
    output logic [NREG-1:0]          wr_pend
);
    logic [NFU-1:0][NREG-1:0] rd_part;
    logic [NFU-1:0][NREG-1:0] wr_part;

    for (genvar f = 0; f < NFU; f++) begin : g_row
        logic [NROLE-1:0][NREG-1:0] fwd_r;
        logic [NROLE-1:0][NREG-1:0] sel_r;

        dm_row #(.NREG(NREG)) u_row (
            .clk     (clk),
            .rst     (rst),
            .issue   (issue[f]),
            .go_rd   (go_rd[f]),
            .go_wr   (go_wr[f]),
            .dst_oh  (dst_oh[f]),
            .s1_oh   (s1_oh[f]),
            .s2_oh   (s2_oh[f]),
            .rd_pend (rd_pend),
            .wr_pend (wr_pend),
            .fwd     (fwd_r),
            .sel     (sel_r),
            .rd_part (rd_part[f]),
            .wr_part (wr_part[f])
        );

        assign dst_fwd[f] = fwd_r[ROLE_DST];
        assign s1_fwd[f]  = fwd_r[ROLE_S1];
        assign s2_fwd[f]  = fwd_r[ROLE_S2];
        assign dst_sel[f] = sel_r[ROLE_DST];
        assign s1_sel[f]  = sel_r[ROLE_S1];
        assign s2_sel[f]  = sel_r[ROLE_S2];
    end

    dm_pend_or #(.NFU(NFU), .NREG(NREG)) u_rd_or (.part(rd_part), .any(rd_pend));
    dm_pend_or #(.NFU(NFU), .NREG(NREG)) u_wr_or (.part(wr_part), .any(wr_pend));
endmodule

// File: rtl/dm_checker.sv
module dm_checker #(
    parameter int unsigned NFU  = 4,
    parameter int unsigned NREG = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic [NFU-1:0]           issue,
    input logic [NFU-1:0]           go_rd,
    input logic [NFU-1:0]           go_wr,
    input logic [NFU-1:0][NREG-1:0] dst_fwd,
    input logic [NFU-1:0][NREG-1:0] s1_fwd,
    input logic [NFU-1:0][NREG-1:0] s2_fwd,
    input logic [NFU-1:0][NREG-1:0] dst_sel,
    input logic [NFU-1:0][NREG-1:0] s1_sel,
    input logic [NFU-1:0][NREG-1:0] s2_sel,
    input logic [NREG-1:0]          rd_pend,
    input logic [NREG-1:0]          wr_pend
);
    // R1
    post_reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && issue == '0) |-> (rd_pend == '0 && wr_pend == '0));

    // R3
    all_dst_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(go_wr) == '1 && $past(issue) == '0 && issue == '0) |-> (wr_pend == '0));

    // R3
    all_src_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(go_rd) == '1 && $past(issue) == '0 && issue == '0) |-> (rd_pend == '0));

    for (genvar f = 0; f < NFU; f++) begin : g_fu
        // R5
        fwd_off_on_issue_chk: assert property (@(posedge clk) disable iff (rst)
            issue[f] |-> (dst_fwd[f] == '0 && s1_fwd[f] == '0 && s2_fwd[f] == '0));

        // R7
        fwd_needs_pending_chk: assert property (@(posedge clk) disable iff (rst)
            ((dst_fwd[f] & ~rd_pend) == '0 && ((s1_fwd[f] | s2_fwd[f]) & ~wr_pend) == '0));

        // R6
        dst_sel_gated_chk: assert property (@(posedge clk) disable iff (rst)
            (dst_sel[f] != '0) |-> (go_wr[f] && (dst_sel[f] & ~wr_pend) == '0));

        // R6
        src_sel_gated_chk: assert property (@(posedge clk) disable iff (rst)
            ((s1_sel[f] | s2_sel[f]) != '0) |-> (go_rd[f] && ((s1_sel[f] | s2_sel[f]) & ~rd_pend) == '0));
    end
endmodule

bind fu_reg_depmatrix dm_checker #(.NFU(NFU), .NREG(NREG)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .issue   (issue),
    .go_rd   (go_rd),
    .go_wr   (go_wr),
    .dst_fwd (dst_fwd),
    .s1_fwd  (s1_fwd),
    .s2_fwd  (s2_fwd),
    .dst_sel (dst_sel),
    .s1_sel  (s1_sel),
    .s2_sel  (s2_sel),
    .rd_pend (rd_pend),
    .wr_pend (wr_pend)
);

// File: tb/sim_fu_reg_depmatrix.sv
module sim_fu_reg_depmatrix;
    localparam int NFU = 4;
    localparam int NREG = 8;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst;
    logic [NFU-1:0] issue, go_rd, go_wr;
    logic [NFU-1:0][NREG-1:0] dst_oh, s1_oh, s2_oh;
    logic [NFU-1:0][NREG-1:0] dst_fwd, s1_fwd, s2_fwd, dst_sel, s1_sel, s2_sel;
    logic [NREG-1:0] rd_pend, wr_pend;

    int n_run = 0;
    int n_fail = 0;

    // model state: recorded bits per row/register/role (0 dst, 1 src1, 2 src2)
    bit mst [NFU][NREG][3];
    bit mlive [NFU][NREG][3];
    bit mact [NFU][NREG][3];
    logic [NFU-1:0][NREG-1:0] e_fwd [3];
    logic [NFU-1:0][NREG-1:0] e_sel [3];
    logic [NREG-1:0] e_rp, e_wp;

    always #(CLK_PERIOD/2) clk = ~clk;

    fu_reg_depmatrix #(.NFU(NFU), .NREG(NREG)) u0 (
        .clk(clk), .rst(rst), .issue(issue), .go_rd(go_rd), .go_wr(go_wr),
        .dst_oh(dst_oh), .s1_oh(s1_oh), .s2_oh(s2_oh),
        .dst_fwd(dst_fwd), .s1_fwd(s1_fwd), .s2_fwd(s2_fwd),
        .dst_sel(dst_sel), .s1_sel(s1_sel), .s2_sel(s2_sel),
        .rd_pend(rd_pend), .wr_pend(wr_pend)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected outputs from the requirements, using current inputs and model state.
    task automatic model_eval();
        for (int f = 0; f < NFU; f++)
            for (int r = 0; r < NREG; r++)
                for (int k = 0; k < 3; k++) begin
                    bit rb, g;
                    rb = (k == 0) ? dst_oh[f][r] : (k == 1) ? s1_oh[f][r] : s2_oh[f][r];
                    g  = (k == 0) ? go_wr[f] : go_rd[f];
                    if (g) mlive[f][r][k] = 1'b0;                  // R4 clear wins
                    else   mlive[f][r][k] = mst[f][r][k] | (issue[f] & rb);
                    mact[f][r][k] = mst[f][r][k] | mlive[f][r][k];
                end
        e_rp = '0; e_wp = '0;
        for (int f = 0; f < NFU; f++)
            for (int r = 0; r < NREG; r++) begin
                if (mact[f][r][1] || mact[f][r][2]) e_rp[r] = 1'b1;
                if (mact[f][r][0]) e_wp[r] = 1'b1;
            end
        for (int k = 0; k < 3; k++) begin
            e_fwd[k] = '0; e_sel[k] = '0;
        end
        for (int f = 0; f < NFU; f++)
            for (int r = 0; r < NREG; r++)
                for (int k = 0; k < 3; k++) begin
                    bit hz, g;
                    hz = (k == 0) ? e_rp[r] : e_wp[r];
                    g  = (k == 0) ? go_wr[f] : go_rd[f];
                    e_fwd[k][f][r] = mact[f][r][k] & hz & ~issue[f];
                    e_sel[k][f][r] = mact[f][r][k] & g;
                end
    endtask

    // One cycle: inputs already driven; compare away from the edge, then clock.
    task automatic step();
        #1;
        model_eval();
        chk(rd_pend == e_rp && wr_pend == e_wp, "R8 pending", {rd_pend, wr_pend}, {e_rp, e_wp});
        chk(dst_fwd == e_fwd[0] && s1_fwd == e_fwd[1] && s2_fwd == e_fwd[2], "R5/R7 fwd",
            {dst_fwd, s1_fwd}, {e_fwd[0], e_fwd[1]});
        chk(dst_sel == e_sel[0] && s1_sel == e_sel[1] && s2_sel == e_sel[2], "R6 sel",
            {dst_sel, s1_sel}, {e_sel[0], e_sel[1]});
        @(posedge clk);
        for (int f = 0; f < NFU; f++)
            for (int r = 0; r < NREG; r++)
                for (int k = 0; k < 3; k++)
                    mst[f][r][k] = rst ? 1'b0 : mlive[f][r][k];
        @(negedge clk);
    endtask

    task automatic idle();
        issue = '0; go_rd = '0; go_wr = '0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        idle();
        dst_oh = '0; s1_oh = '0; s2_oh = '0;
        foreach (mst[f, r, k]) mst[f][r][k] = 1'b0;
        @(negedge clk); @(negedge clk);
        step();
        rst = 1'b0;
        #1;
        // R1 reset state
        chk(rd_pend == '0 && wr_pend == '0 && dst_sel == '0 && s1_fwd == '0, "R1 reset",
            {rd_pend, wr_pend}, 64'h0);
        step();

        // R2 writer FU0: dst r3, src r1, r2
        dst_oh[0] = 8'h08; s1_oh[0] = 8'h02; s2_oh[0] = 8'h04; issue[0] = 1'b1;
        #1;
        chk(wr_pend[3] === 1'b1 && rd_pend[2:1] == 2'b11, "R2 same-cycle capture",
            {wr_pend, rd_pend}, 64'h0806);
        step();
        idle();
        step();
        // dependent reader FU1: src1 r3, dst r5
        dst_oh[1] = 8'h20; s1_oh[1] = 8'h08; s2_oh[1] = 8'h00; issue[1] = 1'b1;
        #1;
        chk(s1_fwd[1] == '0, "R5 fwd off while issuing", s1_fwd[1], 0);
        step();
        idle();
        #1;
        // R7 read-after-write: reader sees writer's pending r3
        chk(s1_fwd[1][3] === 1'b1, "R7 reader hazard", s1_fwd[1], 8'h08);
        step();

        // R3/R6 go-read held two cycles on FU0: select lasts one cycle
        go_rd[0] = 1'b1;
        #1;
        chk(s1_sel[0] == 8'h02 && s2_sel[0] == 8'h04, "R6 go-read select", {s1_sel[0], s2_sel[0]}, 16'h0204);
        chk(s1_sel[1] == '0, "R9 other row unselected", s1_sel[1], 0);
        step();
        #1;
        chk(s1_sel[0] == '0 && s2_sel[0] == '0, "R3 go-read one cycle", {s1_sel[0], s2_sel[0]}, 0);
        chk(rd_pend == 8'h08, "R3 sources cleared, R9 reader kept", rd_pend, 8'h08);
        step();
        idle();
        // go-write FU0
        go_wr[0] = 1'b1;
        #1;
        chk(dst_sel[0] == 8'h08, "R6 go-write select", dst_sel[0], 8'h08);
        step();
        idle();
        #1;
        chk(dst_sel[0] == '0 && wr_pend == 8'h20, "R3 dst cleared", {dst_sel[0], wr_pend}, 16'h0020);
        chk(s1_fwd[1] == '0, "R7 hazard released", s1_fwd[1], 0);
        step();
        go_rd[1] = 1'b1; go_wr[1] = 1'b1;
        step();
        idle();
        #1;
        chk(rd_pend == '0 && wr_pend == '0, "R3 all pending clear", {rd_pend, wr_pend}, 0);
        step();

        // R4 set and clear together on FU2
        dst_oh[2] = 8'h40; issue[2] = 1'b1; go_wr[2] = 1'b1;
        #1;
        chk(wr_pend[6] === 1'b0 && dst_sel[2] == '0, "R4 clear wins same cycle", wr_pend, 0);
        step();
        idle();
        #1;
        chk(wr_pend == '0, "R4 clear wins next cycle", wr_pend, 0);
        step();

        // random phase, model compared every cycle
        for (int i = 0; i < 600; i++) begin
            for (int f = 0; f < NFU; f++) begin
                dst_oh[f] = NREG'(1) << ($urandom % NREG);
                s1_oh[f]  = NREG'(1) << ($urandom % NREG);
                s2_oh[f]  = NREG'(1) << ($urandom % NREG);
                issue[f]  = ($urandom % 4) == 0;
                go_rd[f]  = ($urandom % 5) == 0;
                go_wr[f]  = ($urandom % 5) == 0;
            end
            step();
        end
        idle();
        step();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule